// File: doc/BRIEF.md
# DS3/E3 Alarm Indication Signal Detector

This block watches the receive stream of a DS3 or E3 line after an upstream framer has aligned it. That framer marks each cycle as carrying a payload bit, a C-bit or an X-bit, and it pulses an end-of-frame strobe at every DS3 M-frame end or E3 frame end. The block judges each frame against the alarm pattern for the selected line type. It counts consecutive qualifying frames and raises `ais_out` once enough of them have been seen. It drops the flag after a short run of frames that fail the test.

A DS3 frame qualifies when its payload alternates bit by bit, starting from either value, and when every C-bit in it is 0 and every X-bit in it is 1. An E3 frame qualifies when it holds no more than a set number of zero payload bits. Each frame is judged on its own, because the per-frame trackers restart at every strobe.

Two modules do the work. `ais_frame_qual` gives a verdict on each frame. `ais_persist` is a four-state machine:
- `ST_IDLE`: no alarm, nothing counted.
- `ST_ARM`: counting qualifying frames.
- `ST_ALARM`: alarm raised.
- `ST_HOLD`: alarm raised while counting failing frames.

Its transitions are:
- `IDLE→ARM`: first good frame.
- `ARM→ARM`: good frame, count increases.
- `ARM→ALARM`: set count reached.
- `ARM→IDLE`: bad frame.
- `ALARM→HOLD`: bad frame.
- `HOLD→ALARM`: good frame.
- `HOLD→HOLD`: bad frame, below the clear count.
- `HOLD→IDLE`: clear count reached.
- Any state `→IDLE`: reset or mode change.

Top module: `ais_detector`

## Requirements
- R1: While reset is active and after reset is released, `ais_out` is 0 and every count is empty.
- R2: In DS3 mode (`mode_e3`=0), a frame qualifies only if it has at least one payload bit and each payload bit after the first in that frame is the inverse of the payload bit before it. The starting value of a frame does not matter.
- R3: In DS3 mode, a frame qualifies only if every C-bit in it is 0 and every X-bit in it is 1.
- R4: In DS3 mode, `ais_out` becomes 1 on the clock edge that samples the end strobe of the 63rd consecutive qualifying frame, and not earlier.
- R5: In E3 mode (`mode_e3`=1), a frame qualifies when it has at least one payload bit and at most 7 zero payload bits. A frame with 8 or more zero payload bits fails.
- R6: In E3 mode, `ais_out` becomes 1 on the edge that samples the end strobe of the 2nd consecutive qualifying frame.
- R7: While `ais_out` is 1, it returns to 0 after 2 consecutive failing frames. A single failing frame followed by a qualifying frame keeps it at 1 and restarts the failing count.
- R8: A failing frame seen before the alarm is raised restarts the qualifying count from zero.
- R9: A change of `mode_e3` clears `ais_out` and all counts one edge later. The end strobe in that cycle is ignored.
- R10: Bit qualifiers that are valid in the same cycle as `frame_end` belong to the frame being closed. The next frame starts with empty trackers.
- R11: `ais_out` changes only on an edge that samples `frame_end`, or on a mode change or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_e3 | input | 1 | Line type: 0 = DS3, 1 = E3 |
| pay_bit | input | 1 | Payload bit value |
| pay_vld | input | 1 | `pay_bit` carries a payload bit this cycle |
| cbit | input | 1 | C-bit value |
| cbit_vld | input | 1 | `cbit` carries a C-bit this cycle |
| xbit | input | 1 | X-bit value |
| xbit_vld | input | 1 | `xbit` carries an X-bit this cycle |
| frame_end | input | 1 | Single-cycle strobe closing an M-frame (DS3) or a frame (E3) |
| ais_out | output | 1 | Alarm Indication Signal detected |

## Verification
DS3 frames are sent with both starting phases, so that a phase-locked check would be exposed. The bench also sends frames in which one payload bit repeats its neighbour, frames with a single wrong C-bit or X-bit, and frames that carry no payload bits at all; each of these separates the individual qualification terms. Runs of 62 and 63 good frames, with a fault inserted part way through, pin down the set count and its restart. In E3 mode the bench sends frames with exactly 7 zeros and with 8 zeros. The deciding zero falls in the strobe cycle, which tells apart the threshold and whether that cycle belongs to the frame. Single and paired failing frames separate holding the alarm from clearing it.

// File: rtl/ais_pkg.sv
package ais_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARM   = 2'd1,
        ST_ALARM = 2'd2,
        ST_HOLD  = 2'd3
    } ais_state_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/ais_frame_qual.sv
module ais_frame_qual #(
    parameter int ZERO_MAX = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic mode_e3,
    input  logic pay_bit,
    input  logic pay_vld,
    input  logic cbit,
    input  logic cbit_vld,
    input  logic xbit,
    input  logic xbit_vld,
    input  logic frame_end,
    output logic verdict_vld,
    output logic verdict_ok
);
    localparam int ZW = $clog2(ZERO_MAX + 2);
    localparam logic [ZW-1:0] ZLIM = ZW'(ZERO_MAX);
    localparam logic [ZW-1:0] ZSAT = ZW'(ZERO_MAX + 1);

    logic          seen_q, seen_n;
    logic          prev_q, prev_n;
    logic          alt_q, alt_n;
    logic          oh_q, oh_n;
    logic [ZW-1:0] zcnt_q, zcnt_n;
    logic          ds3_ok, e3_ok;

    // Next tracker values include the bits of the current cycle (R10)
    always_comb begin
        seen_n = seen_q | pay_vld;
        prev_n = pay_vld ? pay_bit : prev_q;
        alt_n  = alt_q & ~(pay_vld & seen_q & (pay_bit == prev_q));
        oh_n   = oh_q & ~(cbit_vld & cbit) & ~(xbit_vld & ~xbit);
        zcnt_n = zcnt_q;
        if (pay_vld && !pay_bit && (zcnt_q <= ZLIM)) begin
            zcnt_n = zcnt_q + ZW'(1);
        end
        ds3_ok = seen_n & alt_n & oh_n;
        e3_ok  = seen_n & (zcnt_n <= ZLIM);
    end

    assign verdict_vld = frame_end & ~clr;
    assign verdict_ok  = mode_e3 ? e3_ok : ds3_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            prev_q <= 1'b0;
            alt_q  <= 1'b1;
            oh_q   <= 1'b1;
            zcnt_q <= '0;
        end else if (clr || frame_end) begin
            seen_q <= 1'b0;
            prev_q <= 1'b0;
            alt_q  <= 1'b1;
            oh_q   <= 1'b1;
            zcnt_q <= '0;
        end else begin
            seen_q <= seen_n;
            prev_q <= prev_n;
            alt_q  <= alt_n;
            oh_q   <= oh_n;
            zcnt_q <= zcnt_n;
        end
    end

    AST_ZCNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        zcnt_q <= ZSAT); // R5

    AST_TRACK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (zcnt_q == '0 && !seen_q && alt_q && oh_q)); // R10

endmodule

// File: rtl/ais_persist.sv
module ais_persist
    import ais_pkg::*;
#(
    parameter int DS3_SET    = 63,
    parameter int E3_SET     = 2,
    parameter int CLR_FRAMES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic mode_e3,
    input  logic verdict_vld,
    input  logic verdict_ok,
    output logic ais
);
    localparam int MAXC = max3(DS3_SET, E3_SET, CLR_FRAMES);
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] ONE     = CW'(1);
    localparam logic [CW-1:0] CLR_TGT = CW'(CLR_FRAMES);

    ais_state_e    state_q, state_n;
    logic [CW-1:0] cnt_q, cnt_n;
    logic [CW-1:0] set_tgt;
    logic [CW-1:0] cnt_inc;

    assign set_tgt = mode_e3 ? CW'(E3_SET) : CW'(DS3_SET);
    assign cnt_inc = cnt_q + ONE;

    // Next-state logic
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (verdict_vld && verdict_ok) begin
                    if (ONE >= set_tgt) begin
                        state_n = ST_ALARM;
                        cnt_n   = '0;
                    end else begin
                        state_n = ST_ARM;
                        cnt_n   = ONE;
                    end
                end
            end
            ST_ARM: begin
                if (verdict_vld) begin
                    if (!verdict_ok) begin
                        state_n = ST_IDLE;        // R8
                        cnt_n   = '0;
                    end else if (cnt_inc >= set_tgt) begin
                        state_n = ST_ALARM;
                        cnt_n   = '0;
                    end else begin
                        cnt_n   = cnt_inc;
                    end
                end
            end
            ST_ALARM: begin
                if (verdict_vld && !verdict_ok) begin
                    if (ONE >= CLR_TGT) begin
                        state_n = ST_IDLE;
                        cnt_n   = '0;
                    end else begin
                        state_n = ST_HOLD;
                        cnt_n   = ONE;
                    end
                end
            end
            ST_HOLD: begin
                if (verdict_vld) begin
                    if (verdict_ok) begin
                        state_n = ST_ALARM;
                        cnt_n   = '0;
                    end else if (cnt_inc >= CLR_TGT) begin
                        state_n = ST_IDLE;
                        cnt_n   = '0;
                    end else begin
                        cnt_n   = cnt_inc;
                    end
                end
            end
            default: begin
                state_n = ST_IDLE;
                cnt_n   = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else if (clr) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_ALARM, ST_HOLD: ais = 1'b1;
            default:           ais = 1'b0;
        endcase
    end

    AST_ARM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARM && !clr) |-> (cnt_q < set_tgt && cnt_q != '0)); // R4

    AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> (cnt_q < CLR_TGT)); // R7

    AST_BAD_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARM && verdict_vld && !verdict_ok) |=> (state_q == ST_IDLE && cnt_q == '0)); // R8

endmodule

// File: rtl/ais_detector.sv
module ais_detector #(
    parameter int DS3_SET    = 63,
    parameter int E3_SET     = 2,
    parameter int CLR_FRAMES = 2,
    parameter int ZERO_MAX   = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_e3,
    input  logic pay_bit,
    input  logic pay_vld,
    input  logic cbit,
    input  logic cbit_vld,
    input  logic xbit,
    input  logic xbit_vld,
    input  logic frame_end,
    output logic ais_out
);
    logic mode_q;
    logic mode_chg;
    logic verdict_vld;
    logic verdict_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
        end else begin
            mode_q <= mode_e3;
        end
    end

    assign mode_chg = mode_q ^ mode_e3;

    ais_frame_qual #(
        .ZERO_MAX (ZERO_MAX)
    ) u_qual (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (mode_chg),
        .mode_e3     (mode_e3),
        .pay_bit     (pay_bit),
        .pay_vld     (pay_vld),
        .cbit        (cbit),
        .cbit_vld    (cbit_vld),
        .xbit        (xbit),
        .xbit_vld    (xbit_vld),
        .frame_end   (frame_end),
        .verdict_vld (verdict_vld),
        .verdict_ok  (verdict_ok)
    );

    ais_persist #(
        .DS3_SET    (DS3_SET),
        .E3_SET     (E3_SET),
        .CLR_FRAMES (CLR_FRAMES)
    ) u_persist (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (mode_chg),
        .mode_e3     (mode_e3),
        .verdict_vld (verdict_vld),
        .verdict_ok  (verdict_ok),
        .ais         (ais_out)
    );

    AST_RISE_ON_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ais_out) |-> $past(verdict_vld && verdict_ok)); // R11

    AST_FALL_ON_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ais_out) |-> $past((verdict_vld && !verdict_ok) || mode_chg)); // R7

    AST_MODE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> !ais_out); // R9

    AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_end && !mode_chg) |=> $stable(ais_out)); // R11

endmodule

// File: tb/ais_detector_bench.sv
module ais_detector_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_e3 = 1'b0;
    logic pay_bit = 1'b0, pay_vld = 1'b0;
    logic cbit = 1'b0, cbit_vld = 1'b0;
    logic xbit = 1'b0, xbit_vld = 1'b0;
    logic frame_end = 1'b0;
    logic ais_out;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Reference model state
    int  good_run = 0;
    int  bad_run = 0;
    bit  m_ais = 1'b0;

    bit    exp_q[$];
    string tag_q[$];
    logic  fe_q = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    ais_detector u_ais_detector (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_e3   (mode_e3),
        .pay_bit   (pay_bit),
        .pay_vld   (pay_vld),
        .cbit      (cbit),
        .cbit_vld  (cbit_vld),
        .xbit      (xbit),
        .xbit_vld  (xbit_vld),
        .frame_end (frame_end),
        .ais_out   (ais_out)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: ais_out=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        good_run = 0;
        bad_run  = 0;
        m_ais    = 1'b0;
    endtask

    function automatic void model_frame(input bit good);
        int tgt;
        tgt = mode_e3 ? 2 : 63;
        if (good) begin
            bad_run = 0;
            good_run++;
            if (!m_ais && good_run >= tgt) m_ais = 1'b1;
        end else begin
            good_run = 0;
            if (m_ais) begin
                bad_run++;
                if (bad_run >= 2) begin
                    m_ais   = 1'b0;
                    bad_run = 0;
                end
            end
        end
    endfunction

    // Monitor: one expected result per sampled end strobe
    always @(posedge clk) fe_q <= frame_end;

    always @(negedge clk) begin
        if (fe_q && rst_n) begin
            if (exp_q.size() == 0) begin
                n_checks++;
                n_fail++;
                $display("FAIL R11: unexpected frame result, actual %b expected none", ais_out);
            end else begin
                check(tag_q.pop_front(), ais_out, exp_q.pop_front());
            end
        end
    end

    task automatic idle_bits();
        pay_vld = 1'b0; cbit_vld = 1'b0; xbit_vld = 1'b0; frame_end = 1'b0;
    endtask

    // DS3 frame: 24 payload bits, C-bits after bits 7/15/23, X-bits after 3/11
    task automatic ds3_frame(input bit ph, input int brk, input bit cbad,
                             input bit xbad, input bit empty, input string req);
        bit b;
        bit good;
        b = ph;
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            idle_bits();
            if (!empty) begin
                pay_vld = 1'b1;
                pay_bit = b;
            end
            b = (i + 1 == brk) ? b : ~b;
            if (i % 8 == 7) begin
                @(negedge clk);
                idle_bits();
                cbit_vld = 1'b1;
                cbit = (cbad && i == 15);
            end
            if (i == 3 || i == 11) begin
                @(negedge clk);
                idle_bits();
                xbit_vld = 1'b1;
                xbit = ~(xbad && i == 11);
            end
        end
        @(negedge clk);
        idle_bits();
        frame_end = 1'b1;
        good = !empty && brk < 0 && !cbad && !xbad;
        model_frame(good);
        exp_q.push_back(m_ais);
        tag_q.push_back(req);
        @(negedge clk);
        idle_bits();
    endtask

    // E3 frame: 32 payload bits, the last nz are zero; the last bit rides with the strobe (R10)
    task automatic e3_frame(input int nz, input string req);
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            idle_bits();
            pay_vld = 1'b1;
            pay_bit = (i < 32 - nz);
            if (i == 31) begin
                frame_end = 1'b1;
                model_frame(nz <= 7);
                exp_q.push_back(m_ais);
                tag_q.push_back(req);
            end
        end
        @(negedge clk);
        idle_bits();
    endtask

    task automatic switch_mode(input logic m);
        @(negedge clk);
        mode_e3 = m;
        @(negedge clk);
        check("R9", ais_out, 1'b0);
        model_reset();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not end, actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", ais_out, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", ais_out, 1'b0);

        // R4 with both starting phases (R2)
        for (int k = 0; k < 63; k++) ds3_frame(k[0], -1, 1'b0, 1'b0, 1'b0, "R4");
        // single bad then good keeps alarm (R7)
        ds3_frame(1'b0, 9, 1'b0, 1'b0, 1'b0, "R2");
        ds3_frame(1'b1, -1, 1'b0, 1'b0, 1'b0, "R7");
        // two bad overhead frames clear (R3, R7)
        ds3_frame(1'b0, -1, 1'b1, 1'b0, 1'b0, "R3");
        ds3_frame(1'b1, -1, 1'b0, 1'b1, 1'b0, "R3");
        check("R7", ais_out, 1'b0);

        // R8: bad frame after 40 good restarts the count
        for (int k = 0; k < 40; k++) ds3_frame(k[0], -1, 1'b0, 1'b0, 1'b0, "R8");
        ds3_frame(1'b1, 20, 1'b0, 1'b0, 1'b0, "R8");
        for (int k = 0; k < 62; k++) ds3_frame(~k[0], -1, 1'b0, 1'b0, 1'b0, "R8");
        check("R8", ais_out, 1'b0);
        ds3_frame(1'b0, -1, 1'b0, 1'b0, 1'b0, "R4");
        check("R4", ais_out, 1'b1);
        // empty frames fail (R2)
        ds3_frame(1'b0, -1, 1'b0, 1'b0, 1'b1, "R2");
        ds3_frame(1'b0, -1, 1'b0, 1'b0, 1'b1, "R2");
        check("R2", ais_out, 1'b0);
        ds3_frame(1'b1, -1, 1'b0, 1'b0, 1'b0, "R2");
        ds3_frame(1'b0, 23, 1'b0, 1'b0, 1'b0, "R2");

        // E3 mode
        switch_mode(1'b1);
        e3_frame(7, "R5");
        e3_frame(8, "R10");
        e3_frame(0, "R8");
        e3_frame(7, "R6");
        check("R6", ais_out, 1'b1);
        e3_frame(20, "R7");
        e3_frame(3, "R7");
        e3_frame(8, "R7");
        e3_frame(9, "R7");
        check("R7", ais_out, 1'b0);
        e3_frame(1, "R6");
        e3_frame(2, "R6");

        // mode change clears an active alarm (R9)
        check("R9", ais_out, 1'b1);
        switch_mode(1'b0);
        switch_mode(1'b1);
        e3_frame(0, "R6");
        e3_frame(0, "R6");

        // reset clears an active alarm (R1)
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", ais_out, 1'b0);
        rst_n = 1'b1;
        model_reset();
        repeat (3) @(negedge clk);
        check("R1", ais_out, 1'b0);
        e3_frame(5, "R6");
        e3_frame(6, "R6");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_checks++;
            n_fail++;
            $display("FAIL R11: %0d frame results missing, expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule